// File: doc/BRIEF.md
# Framed Serial Port Transmitter

This block sends parallel words as a serial bit stream. It runs entirely on an externally supplied bit clock and takes its word timing from an external frame-sync input. Software-side logic writes a word into a holding buffer. A frame sync seen high on a rising clock edge moves that word into a shift register, and the word then leaves on the data pin most significant bit first, one bit per rising edge. A mode input selects the word length, either 8 or 16 bits. A buffer-empty flag and a one-cycle interrupt tell the writer when a new word may be supplied. After the last bit the pin returns to high impedance.

The sequencing is done by a three-state machine. The states are `ST_IDLE` (pin released), `ST_LEAD` (first bit on the pin, waiting for frame sync to drop) and `ST_SHIFT` (remaining bits moving out). The transitions are as follows:
- IDLE→LEAD when frame sync is high; this loads the shifter.
- LEAD→LEAD while frame sync stays high; this holds the first bit.
- LEAD→SHIFT when frame sync is low; this shifts once and raises the interrupt.
- SHIFT→SHIFT while bits remain.
- SHIFT→LEAD on the last bit with frame sync high; this is a back-to-back frame and reloads the shifter.
- SHIFT→IDLE on the last bit with frame sync low.

The logic is fully static. No transition depends on how many clocks pass between frames, so the clock may stop for any length of time.

Top module: `fsp_tx`

## Requirements
- R1: A synchronous active-high reset returns the machine to idle, drives `tx_oe` low and `tx_irq` low, and sets `buf_empty` high.
- R2: A cycle with `wr_en` high stores `wr_data` in the buffer, and `buf_empty` reads low after that edge.
- R3: Frame sync high at a rising edge while idle (or while the last bit is on the pin) loads the shifter from the buffer. After that edge `tx_oe` is high, the pin carries the word's MSB, and `buf_empty` is high.
- R4: Bits leave MSB first, one per rising edge. With `wide` = 1 the sent word is `wr_data[15:0]` starting at bit 15. With `wide` = 0 it is `wr_data[7:0]` starting at bit 7.
- R5: While frame sync stays high past the starting edge, the first bit holds on the pin. The second bit appears after the first rising edge at which frame sync is low.
- R6: `tx_irq` is high for exactly one cycle, after the first edge at which frame sync is seen low following a frame start. It stays low while frame sync is held high.
- R7: With the last bit on the pin and frame sync low at the next edge, `tx_oe` goes low after that edge and the pin is high impedance.
- R8: With the last bit on the pin and frame sync high at the next edge, the next word's MSB follows with no idle cycle.
- R9: If no word was written since the last load, a new frame resends the previous word.
- R10: The word length is captured at frame start. A change of `wide` during a frame does not change the length of that frame.
- R11: A write during a frame does not alter the bits of the word in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | External bit clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | 16 | Word to be sent |
| wide | input | 1 | Word length: 1 = 16 bits, 0 = 8 bits |
| fsync | input | 1 | External frame sync |
| tx_pin | output | 1 | Serial data pin, high impedance when disabled |
| tx_oe | output | 1 | Data output enable |
| buf_empty | output | 1 | Transmit buffer is free for a new word |
| tx_irq | output | 1 | One-cycle buffer-empty interrupt |

## Verification
The assertions assume that `fsync`, `wr_en` and `wide` change only away from the rising clock edge. They also assume that a frame sync arriving while a word is still mid-shift is not intended as a new frame; the machine ignores it. The bench drives every input on the falling edge and raises frame sync only when the port is idle or when the last bit is on the pin. It holds frame sync high for several cycles in one case so that the long-pulse path is covered without breaking these assumptions.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2
    } fsp_state_e;
endpackage

// File: rtl/fsp_txbuf.sv
module fsp_txbuf #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output logic [DATA_W-1:0] buf_q,
    output logic              buf_empty
);
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q     <= '0;
            buf_empty <= 1'b1;
        end else if (wr_en) begin
            buf_q     <= wr_data;
            buf_empty <= 1'b0;
        end else if (load) begin
            buf_empty <= 1'b1;
        end
    end

    // R2
    write_clears_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && !rst) |-> !buf_empty);

    // R3
    load_sets_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $past(load && !wr_en && !rst) |-> buf_empty);
endmodule

// File: rtl/fsp_shifter.sv
module fsp_shifter #(
    parameter int DATA_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic              wide_in,
    input  logic [DATA_W-1:0] buf_q,
    output logic              tx_bit,
    output logic              last_bit
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam int PAD_W = DATA_W - SHORT_W;
    localparam logic [CNT_W-1:0] LAST_WIDE  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);

    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wide_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            wide_q <= 1'b1;
        end else if (load) begin
            wide_q <= wide_in;
            cnt_q  <= '0;
            sh_q   <= wide_in ? buf_q : {buf_q[SHORT_W-1:0], {PAD_W{1'b0}}};
        end else if (shift) begin
            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tx_bit   = sh_q[DATA_W-1];
    assign last_bit = (cnt_q == (wide_q ? LAST_WIDE : LAST_SHORT));

    // R10
    no_shift_past_end_chk: assert property (@(posedge clk) disable iff (rst)
        shift |-> !last_bit);
endmodule

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
    import fsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fsync,
    input  logic       last_bit,
    output logic       load,
    output logic       shift,
    output logic       tx_oe,
    output logic       tx_irq,
    output fsp_state_e st
);
    fsp_state_e nxt;
    logic       irq_set;

    always_comb begin
        nxt     = st;
        load    = 1'b0;
        shift   = 1'b0;
        irq_set = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (fsync) begin
                    nxt  = ST_LEAD;
                    load = 1'b1;
                end
            end
            ST_LEAD: begin
                if (!fsync) begin
                    nxt     = ST_SHIFT;
                    shift   = 1'b1;
                    irq_set = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (!last_bit) begin
                    shift = 1'b1;
                end else if (fsync) begin
                    nxt  = ST_LEAD;
                    load = 1'b1;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) tx_irq <= 1'b0;
        else     tx_irq <= irq_set;
    end

    assign tx_oe = (st != ST_IDLE);

    // R3
    oe_needs_fsync_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_oe) |-> $past(fsync));

    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        tx_irq |=> !tx_irq);

    // R6
    irq_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> !$past(fsync));

    // R7
    release_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SHIFT && last_bit && !fsync) |=> !tx_oe);
endmodule

// File: rtl/fsp_tx.sv
module fsp_tx
    import fsp_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wide,
    input  logic              fsync,
    output logic              tx_pin,
    output logic              tx_oe,
    output logic              buf_empty,
    output logic              tx_irq
);
    logic [DATA_W-1:0] buf_q;
    logic              load;
    logic              shift;
    logic              tx_bit;
    logic              last_bit;
    fsp_state_e        st;

    fsp_txbuf #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .load(load), .buf_q(buf_q), .buf_empty(buf_empty)
    );

    fsp_shifter #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_sh (
        .clk(clk), .rst(rst), .load(load), .shift(shift), .wide_in(wide),
        .buf_q(buf_q), .tx_bit(tx_bit), .last_bit(last_bit)
    );

    fsp_ctrl u_ctrl (
        .clk(clk), .rst(rst), .fsync(fsync), .last_bit(last_bit),
        .load(load), .shift(shift), .tx_oe(tx_oe), .tx_irq(tx_irq), .st(st)
    );

    assign tx_pin = tx_oe ? tx_bit : 1'bz;

    // R5
    lead_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LEAD && $past(st == ST_LEAD)) |-> $stable(tx_bit));
endmodule

// File: tb/fsp_tx_tb.sv
module fsp_tx_tb;
    localparam int CLK_P = 10;
    localparam int NVEC  = 19;
    // {fsync, exp_oe, exp_bit, exp_irq, check_bit}; word 16'hA5C3, wide mode, long frame sync
    localparam logic [4:0] VEC [NVEC] = '{
        5'b11101, 5'b11101, 5'b11101, 5'b01011, 5'b01101,
        5'b01001, 5'b01001, 5'b01101, 5'b01001, 5'b01101,
        5'b01101, 5'b01101, 5'b01001, 5'b01001, 5'b01001,
        5'b01001, 5'b01101, 5'b01101, 5'b00000
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wide = 1'b1;
    logic        fsync = 1'b0;
    wire         tx_pin;
    logic        tx_oe, buf_empty, tx_irq;
    int          tests = 0;
    int          fails = 0;
    bit          done = 1'b0;

    fsp_tx u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wide(wide),
        .fsync(fsync), .tx_pin(tx_pin), .tx_oe(tx_oe),
        .buf_empty(buf_empty), .tx_irq(tx_irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic fs, input logic we, input logic [15:0] d);
        @(negedge clk);
        fsync   = fs;
        wr_en   = we;
        wr_data = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] w;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 oe", tx_oe, 1'b0);
        chk("R1 empty", buf_empty, 1'b1);
        chk("R1 irq", tx_irq, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // table: 16-bit word, frame sync held three cycles
        wide = 1'b1;
        cyc(1'b0, 1'b1, 16'hA5C3);
        chk("R2 empty low", buf_empty, 1'b0);
        for (int i = 0; i < NVEC; i++) begin
            cyc(VEC[i][4], 1'b0, 16'h0);
            chk("R3/R7 oe", tx_oe, VEC[i][3]);
            if (VEC[i][0]) chk("R4/R5 bit", tx_pin, VEC[i][2]);
            chk("R6 irq", tx_irq, VEC[i][1]);
            if (i == 0) chk("R3 empty set", buf_empty, 1'b1);
        end

        // 8-bit mode, normal one-clock frame sync
        wide = 1'b0;
        w = 8'hC5;
        cyc(1'b0, 1'b1, 16'h12C5);
        cyc(1'b1, 1'b0, 16'h0);
        chk("R3 oe", tx_oe, 1'b1);
        chk("R4 msb8", tx_pin, w[7]);
        for (int k = 6; k >= 0; k--) begin
            cyc(1'b0, 1'b0, 16'h0);
            chk("R4 bit8", tx_pin, w[k]);
            if (k == 6) chk("R6 irq", tx_irq, 1'b1);
        end
        cyc(1'b0, 1'b0, 16'h0);
        chk("R7 release", tx_oe, 1'b0);

        // R9: no write, same word again
        cyc(1'b1, 1'b0, 16'h0);
        chk("R9 msb", tx_pin, w[7]);
        for (int k = 6; k >= 0; k--) begin
            cyc(1'b0, 1'b0, 16'h0);
            chk("R9 bit", tx_pin, w[k]);
        end
        cyc(1'b0, 1'b0, 16'h0);
        chk("R9 release", tx_oe, 1'b0);

        // R11: write mid-frame, then R8: back-to-back frame
        cyc(1'b1, 1'b0, 16'h0);
        chk("R11 msb", tx_pin, w[7]);
        cyc(1'b0, 1'b1, 16'h003C);
        chk("R11 bit6", tx_pin, w[6]);
        for (int k = 5; k >= 0; k--) begin
            cyc(1'b0, 1'b0, 16'h0);
            chk("R11 bit", tx_pin, w[k]);
        end
        w = 8'h3C;
        cyc(1'b1, 1'b0, 16'h0);
        chk("R8 oe kept", tx_oe, 1'b1);
        chk("R8 msb", tx_pin, w[7]);
        for (int k = 6; k >= 0; k--) begin
            cyc(1'b0, 1'b0, 16'h0);
            chk("R8 bit", tx_pin, w[k]);
        end
        cyc(1'b0, 1'b0, 16'h0);
        chk("R8 release", tx_oe, 1'b0);

        // R10: length captured at start
        w = 8'hF0;
        cyc(1'b0, 1'b1, 16'hAAF0);
        cyc(1'b1, 1'b0, 16'h0);
        wide = 1'b1;
        for (int k = 6; k >= 0; k--) begin
            cyc(1'b0, 1'b0, 16'h0);
            chk("R10 bit", tx_pin, w[k]);
        end
        cyc(1'b0, 1'b0, 16'h0);
        chk("R10 eight bits only", tx_oe, 1'b0);

        // R1: reset in the middle of a frame
        cyc(1'b0, 1'b1, 16'h1234);
        cyc(1'b1, 1'b0, 16'h0);
        @(negedge clk);
        rst = 1'b1;
        fsync = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 mid oe", tx_oe, 1'b0);
        chk("R1 mid empty", buf_empty, 1'b1);
        chk("R1 mid irq", tx_irq, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule